// File: doc/BRIEF.md
# Stacking Bus Arbiter

This block controls access to a shared data bus that links a small stack of repeater units. One unit in the stack is strapped as the arbitrating unit. It samples its own transmit request and the request lines of up to three neighbours on every clock edge. If exactly one request is present, it pulls the active-low acknowledge line. If two or more are present, it withholds the acknowledge and pulls the active-low collision line so that every unit sees the conflict. The grant is exclusive only. Simultaneous requests are never resolved by priority.

Every unit, the arbitrating one included, uses the acknowledge and collision it sees to pick its role for the cycle. A unit that is requesting and sees an acknowledge owns the bus and drives its transmit word onto the data lines. A unit that sees an acknowledge without requesting captures the data lines as a receiver. A unit that is not strapped as arbiter, or whose external-arbiter strap is set, leaves acknowledge and collision undriven and takes both from the pins. Bidirectional pins appear as separate input, output and output-enable signals. The data width is a parameter: 4 for the fast domain, 1 for the slow one.

Top module: `stack_bus_arbiter`

## Requirements
- R1: `ack_n_oe` and `col_n_oe` are 1 exactly when `master_strap`=1 and `ext_arb_strap`=0, and 0 in every other strap combination.
- R2: With the internal arbiter on, if exactly one of the four request bits ({`remote_req`, `local_req`}) is 1 at a clock edge, then after that edge `ack_n_out`=0 and `col_n_out`=1.
- R3: With the internal arbiter on, if two or more request bits are 1 at an edge, then after that edge `ack_n_out`=1 and `col_n_out`=0.
- R4: With the internal arbiter on, if no request bit is 1 at an edge, then after that edge `ack_n_out`=1 and `col_n_out`=1.
- R5: With the internal arbiter off, the unit uses `ack_n_in` and `col_n_in` as the acknowledge and collision it sees, and `remote_req` has no effect on any output.
- R6: When the seen acknowledge is low, the seen collision is high and `local_req`=1, then `own_bus`=1, `bus_d_oe`=1 and `bus_d_out`=`tx_data` in the same cycle. Otherwise `bus_d_oe`=0.
- R7: When the seen acknowledge is low, the seen collision is high and `local_req`=0 at an edge, then after that edge `rx_valid`=1 and `rx_data` holds the `bus_d_in` value from that edge. Otherwise `rx_valid`=0 and `rx_data` keeps its value.
- R8: When the seen collision is low, `collision`=1, `bus_d_oe`=0 and no data is captured, whatever the acknowledge is.
- R9: A clock edge with `rst_n`=0 sets `ack_n_out`=1, `col_n_out`=1, `rx_valid`=0 and `rx_data`=0.
- R10: With `DATA_W`=1, the bus drive and the receive capture behave as in R6 and R7 on a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_strap | input | 1 | 1 = this unit is the stack's arbitrating unit |
| ext_arb_strap | input | 1 | 1 = an external device arbitrates; the internal arbiter is off |
| local_req | input | 1 | This unit wants to transmit on the bus |
| remote_req | input | N_REMOTE | Request lines from the other units |
| req_out | output | 1 | This unit's request, driven to the bus |
| ack_n_in | input | 1 | Acknowledge pin, input side (active low) |
| ack_n_out | output | 1 | Acknowledge pin, output value (active low) |
| ack_n_oe | output | 1 | Acknowledge pin output enable |
| col_n_in | input | 1 | Collision pin, input side (active low) |
| col_n_out | output | 1 | Collision pin, output value (active low) |
| col_n_oe | output | 1 | Collision pin output enable |
| tx_data | input | DATA_W | Word to drive while owning the bus |
| bus_d_in | input | DATA_W | Data lines, input side |
| bus_d_out | output | DATA_W | Data lines, output value |
| bus_d_oe | output | 1 | Data lines output enable |
| rx_data | output | DATA_W | Last word captured as a receiver |
| rx_valid | output | 1 | `rx_data` was captured on the last edge |
| own_bus | output | 1 | This unit currently owns the bus |
| collision | output | 1 | A collision is seen on the bus |

## Verification
On the arbitrating unit, the grant it computes from its own request and its role decision fall in the same cycle. The unit can be granted to itself and drive, be granted to a neighbour and receive, or be caught in a collision it produced itself. All sixteen request patterns are applied, and each one is checked one edge later against the popcount of the request vector and the value of the local request bit. A second overlap is a low acknowledge together with a low collision on the input pins of a non-arbitrating unit. This is provoked by sweeping every combination of the two pins with both request states, and the expected result is that collision wins: no drive and no capture.

// File: rtl/stack_bus_pkg.sv
// Shared types for the stacking bus arbiter.
// Assumes: one role per unit per cycle, decided from the seen ack/collision.
package stack_bus_pkg;

    // Role of the unit on the shared bus in the current cycle
    typedef enum logic [1:0] {
        ROLE_IDLE  = 2'd0,
        ROLE_DRIVE = 2'd1,
        ROLE_RECV  = 2'd2,
        ROLE_COLL  = 2'd3
    } bus_role_e;

endpackage

// File: rtl/stack_req_arbiter.sv
// Exclusive-grant arbiter for the stacking bus.
// Samples the request vector each edge; a single requester gets a low
// acknowledge, several requesters get a low collision broadcast.
// Assumes: arb_en is quasi-static (strap derived); when off, outputs idle high.
module stack_req_arbiter #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_en,
    input  logic [N_REQ-1:0] req_vec,
    output logic             ack_n_q,
    output logic             col_n_q
);

    localparam int CNT_W = $clog2(N_REQ + 1);

    logic [CNT_W-1:0] req_cnt;
    logic             one_req;
    logic             many_req;

    // Count the active request bits
    always_comb begin
        req_cnt = '0;
        for (int i = 0; i < N_REQ; i++) begin
            req_cnt = req_cnt + CNT_W'(req_vec[i]);
        end
    end

    // Classify the request count
    always_comb begin
        one_req  = (req_cnt == CNT_W'(1));
        many_req = (req_cnt > CNT_W'(1));
    end

    // Register acknowledge and collision (active low)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_n_q <= 1'b1;
            col_n_q <= 1'b1;
        end else if (!arb_en) begin
            ack_n_q <= 1'b1;
            col_n_q <= 1'b1;
        end else begin
            ack_n_q <= !one_req;
            col_n_q <= !many_req;
        end
    end

    // R2: a lone request is acknowledged one edge later
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arb_en && $countones(req_vec) == 1 |=> !ack_n_q && col_n_q);

    // R3: several requests give collision and no acknowledge
    p_multi_collide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arb_en && $countones(req_vec) > 1 |=> ack_n_q && !col_n_q);

    // R4: an empty request vector releases both lines
    p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_en && req_vec == '0 |=> ack_n_q && col_n_q);

    // R1: a disabled arbiter stays quiet
    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> ack_n_q && col_n_q);

endmodule

// File: rtl/stack_bus_role.sv
// Role decision for one unit on the stacking bus.
// Collision wins over acknowledge; an acknowledge with a local request
// means drive, without one it means receive.
// Assumes: ack_n/col_n are already the effective (internal or pin) values.
module stack_bus_role
    import stack_bus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ack_n,
    input  logic      col_n,
    input  logic      local_req,
    output bus_role_e role
);

    // Pick this cycle's role from the seen lines and the local request
    always_comb begin
        if (!col_n) begin
            role = ROLE_COLL;
        end else if (!ack_n) begin
            role = local_req ? ROLE_DRIVE : ROLE_RECV;
        end else begin
            role = ROLE_IDLE;
        end
    end

    // R8: a seen collision never yields a drive or a receive role
    p_col_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !col_n |-> role == ROLE_COLL);

    // R6: driving requires an own request
    p_drive_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        role == ROLE_DRIVE |-> local_req && !ack_n);

endmodule

// File: rtl/stack_rx_capture.sv
// Receive capture register for the stacking bus data lines.
// Captures the data lines on every edge where the unit is a receiver.
// Assumes: bus_d_in is synchronous to clk.
module stack_rx_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);

    // Capture data and flag its arrival
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= take;
            if (take) begin
                rx_data <= bus_d_in;
            end
        end
    end

    // R7: without a receive role the captured word holds
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rx_data) && !rx_valid);

    // R7: a receive role yields the sampled word next cycle
    p_rx_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> rx_valid && rx_data == $past(bus_d_in));

endmodule

// File: rtl/stack_bus_arbiter.sv
// Stacking bus arbiter top.
// On the arbitrating unit, runs the internal arbiter over the local and
// remote requests and drives acknowledge/collision. Otherwise it takes both
// from the pins. Every unit then drives or receives the data lines.
// Assumes: bidirectional pins are split into in/out/oe; sync active-low reset.
module stack_bus_arbiter
    import stack_bus_pkg::*;
#(
    parameter int DATA_W   = 4,
    parameter int N_REMOTE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_strap,
    input  logic                ext_arb_strap,
    input  logic                local_req,
    input  logic [N_REMOTE-1:0] remote_req,
    output logic                req_out,
    input  logic                ack_n_in,
    output logic                ack_n_out,
    output logic                ack_n_oe,
    input  logic                col_n_in,
    output logic                col_n_out,
    output logic                col_n_oe,
    input  logic [DATA_W-1:0]   tx_data,
    input  logic [DATA_W-1:0]   bus_d_in,
    output logic [DATA_W-1:0]   bus_d_out,
    output logic                bus_d_oe,
    output logic [DATA_W-1:0]   rx_data,
    output logic                rx_valid,
    output logic                own_bus,
    output logic                collision
);

    localparam int N_REQ = N_REMOTE + 1;

    logic             arb_en;
    logic [N_REQ-1:0] req_vec;
    logic             ack_n_q;
    logic             col_n_q;
    logic             ack_n_eff;
    logic             col_n_eff;
    bus_role_e        role;

    // Enable the internal arbiter from the straps
    always_comb begin
        arb_en  = master_strap && !ext_arb_strap;
        req_vec = {remote_req, local_req};
    end

    stack_req_arbiter #(.N_REQ(N_REQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .arb_en  (arb_en),
        .req_vec (req_vec),
        .ack_n_q (ack_n_q),
        .col_n_q (col_n_q)
    );

    // Select the seen acknowledge/collision and drive the pins
    always_comb begin
        ack_n_eff = arb_en ? ack_n_q : ack_n_in;
        col_n_eff = arb_en ? col_n_q : col_n_in;
        ack_n_out = ack_n_q;
        col_n_out = col_n_q;
        ack_n_oe  = arb_en;
        col_n_oe  = arb_en;
        req_out   = local_req;
    end

    stack_bus_role u_role (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n     (ack_n_eff),
        .col_n     (col_n_eff),
        .local_req (local_req),
        .role      (role)
    );

    // Drive the data lines only while owning the bus
    always_comb begin
        own_bus   = (role == ROLE_DRIVE);
        collision = (role == ROLE_COLL);
        bus_d_oe  = own_bus;
        bus_d_out = own_bus ? tx_data : '0;
    end

    stack_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (role == ROLE_RECV),
        .bus_d_in (bus_d_in),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    // R1: pin drivers follow the straps
    p_oe_strap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n_oe == (master_strap && !ext_arb_strap) && col_n_oe == ack_n_oe);

    // R6: data drive implies own request and no collision on the seen lines
    p_drive_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> local_req && col_n_eff && !ack_n_eff);

    // R5: with the arbiter off the pins decide the role
    p_pins_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en && !col_n_in |-> collision && !bus_d_oe);

endmodule

// File: tb/tb_stack_bus_arbiter.sv
// Self-checking bench: sweeps every request pattern on the arbitrating unit
// and every pin/request combination on non-arbitrating units.
module tb_stack_bus_arbiter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master = 1'b0;
    logic       ext = 1'b0;
    logic       local_req = 1'b0;
    logic [2:0] remote = '0;
    logic       ack_n_in = 1'b1;
    logic       col_n_in = 1'b1;
    logic [3:0] tx = '0;
    logic [3:0] bin = '0;

    logic       req_out, ack_n_out, ack_n_oe, col_n_out, col_n_oe;
    logic [3:0] bus_d_out, rx_data;
    logic       bus_d_oe, rx_valid, own_bus, collision;

    logic       w_req_out, w_ack_n_out, w_ack_n_oe, w_col_n_out, w_col_n_oe;
    logic [0:0] w_bus_d_out, w_rx_data;
    logic       w_bus_d_oe, w_rx_valid, w_own_bus, w_collision;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stack_bus_arbiter #(.DATA_W(4), .N_REMOTE(3)) dut (
        .clk(clk), .rst_n(rst_n), .master_strap(master), .ext_arb_strap(ext),
        .local_req(local_req), .remote_req(remote), .req_out(req_out),
        .ack_n_in(ack_n_in), .ack_n_out(ack_n_out), .ack_n_oe(ack_n_oe),
        .col_n_in(col_n_in), .col_n_out(col_n_out), .col_n_oe(col_n_oe),
        .tx_data(tx), .bus_d_in(bin), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .own_bus(own_bus),
        .collision(collision)
    );

    stack_bus_arbiter #(.DATA_W(1), .N_REMOTE(3)) dut_w1 (
        .clk(clk), .rst_n(rst_n), .master_strap(master), .ext_arb_strap(ext),
        .local_req(local_req), .remote_req(remote), .req_out(w_req_out),
        .ack_n_in(ack_n_in), .ack_n_out(w_ack_n_out), .ack_n_oe(w_ack_n_oe),
        .col_n_in(col_n_in), .col_n_out(w_col_n_out), .col_n_oe(w_col_n_oe),
        .tx_data(tx[0:0]), .bus_d_in(bin[0:0]), .bus_d_out(w_bus_d_out),
        .bus_d_oe(w_bus_d_oe), .rx_data(w_rx_data), .rx_valid(w_rx_valid),
        .own_bus(w_own_bus), .collision(w_collision)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_rx;
        logic       exp_rx1;

        exp_rx  = '0;
        exp_rx1 = 1'b0;

        // R9: reset with busy inputs
        master = 1'b1; local_req = 1'b1; remote = 3'b111; bin = 4'hF;
        repeat (2) @(posedge clk);
        #1;
        chk("R9", "ack_n_out", ack_n_out, 1);
        chk("R9", "col_n_out", col_n_out, 1);
        chk("R9", "rx_valid", rx_valid, 0);
        chk("R9", "rx_data", rx_data, 0);
        @(negedge clk);
        rst_n = 1'b1; local_req = 1'b0; remote = '0;
        @(posedge clk);

        // Arbitrating unit: all sixteen request patterns
        for (int p = 0; p < 16; p++) begin
            int cnt;
            bit lp;
            @(negedge clk);
            local_req = p[0];
            remote = 3'(p >> 1);
            tx  = 4'(p) ^ 4'h5;
            bin = ~4'(p);
            lp  = p[0];
            cnt = p[0] + p[1] + p[2] + p[3];
            @(posedge clk);
            #1;
            chk("R1", "ack_n_oe master", ack_n_oe, 1);
            chk("R1", "col_n_oe master", col_n_oe, 1);
            chk("R2", "ack_n_out", ack_n_out, (cnt == 1) ? 0 : 1);
            chk("R3", "col_n_out", col_n_out, (cnt >= 2) ? 0 : 1);
            chk("R6", "bus_d_oe", bus_d_oe, (cnt == 1 && lp) ? 1 : 0);
            chk("R6", "own_bus", own_bus, (cnt == 1 && lp) ? 1 : 0);
            if (cnt == 1 && lp) begin
                chk("R6", "bus_d_out", bus_d_out, tx);
                chk("R10", "w1 bus_d_out", w_bus_d_out, tx[0]);
            end
            chk("R8", "collision", collision, (cnt >= 2) ? 1 : 0);
            @(posedge clk);
            #1;
            if (cnt == 1 && !lp) begin
                exp_rx  = bin;
                exp_rx1 = bin[0];
            end
            chk("R7", "rx_valid", rx_valid, (cnt == 1 && !lp) ? 1 : 0);
            chk("R7", "rx_data", rx_data, exp_rx);
            chk("R10", "w1 rx_data", w_rx_data, exp_rx1);
            chk("R10", "w1 rx_valid", w_rx_valid, (cnt == 1 && !lp) ? 1 : 0);
            // release all requests; a held grant makes one more capture
            @(negedge clk);
            local_req = 1'b0;
            remote = '0;
            @(posedge clk);
            #1;
            if (cnt == 1) begin
                exp_rx  = bin;
                exp_rx1 = bin[0];
            end
            chk("R4", "ack_n_out released", ack_n_out, 1);
            chk("R4", "col_n_out released", col_n_out, 1);
        end

        // Non-arbitrating unit and external-arbiter mode
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            master = (m == 1);
            ext    = (m == 1);
            for (int q = 0; q < 64; q++) begin
                bit a, c, l, e_drv, e_rcv;
                @(negedge clk);
                a = q[0]; c = q[1]; l = q[2];
                ack_n_in  = a;
                col_n_in  = c;
                local_req = l;
                remote    = 3'(q >> 3);
                tx  = 4'(q);
                bin = 4'(q >> 2) ^ 4'hA;
                e_drv = !a && c && l;
                e_rcv = !a && c && !l;
                @(posedge clk);
                #1;
                chk("R1", "ack_n_oe off", ack_n_oe, 0);
                chk("R1", "col_n_oe off", col_n_oe, 0);
                chk("R5", "bus_d_oe from pins", bus_d_oe, e_drv);
                chk("R6", "own_bus from pins", own_bus, e_drv);
                if (e_drv) begin
                    chk("R6", "bus_d_out from pins", bus_d_out, tx);
                    chk("R10", "w1 bus_d_out from pins", w_bus_d_out, tx[0]);
                end
                chk("R8", "collision from pins", collision, !c);
                if (e_rcv) begin
                    exp_rx  = bin;
                    exp_rx1 = bin[0];
                end
                chk("R7", "rx_valid from pins", rx_valid, e_rcv);
                chk("R5", "rx_data from pins", rx_data, exp_rx);
                chk("R10", "w1 rx_data from pins", w_rx_data, exp_rx1);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule